// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Bus

This block is the control front end of a stereo tone and volume processor. It watches a two-wire serial bus (SCL and SDA, both open drain) with a fast system clock. It accepts write transfers addressed to one fixed device address and loads the payload into eight 8-bit control registers. Those registers drive the analog setting decoders that sit outside this block. The block only receives and acknowledges. It never returns data, never stretches the clock and never takes part in arbitration.

A transfer has a fixed order. It opens with a START condition, followed by the address byte. Next comes a subaddress byte. Its low nibble picks the first register to write, and bit 4 decides whether later bytes go to that same register or step through the following ones. Every data byte up to the STOP is then loaded into the bank. The block acknowledges each byte it accepts by pulling SDA low for the ninth clock.

The register contents leave the block as held levels and need no handshake. The bus has no back-pressure: every accepted byte reaches the bank within a few system clocks of the falling SCL edge that ends its eighth bit. On reset each register takes a fixed default value.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset, `regs_o` bytes 0 to 7 are 0x02, 0x0E, 0xFF, 0x00, 0x0E, 0x0E, 0xFF, 0xFF. Byte k sits at bits [8k+7:8k]. While the bus is idle after reset, `sda_pull_o` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked without a preceding START are ignored: they are neither acknowledged nor stored. A STOP ends the transfer.
- R3: An address byte equal to 0x88 is acknowledged. Any other address byte, including 0x89 with the read bit set, is not acknowledged, and the block then ignores all bytes until the next START.
- R4: The subaddress byte is acknowledged. Bits [3:0] give the register index and bit 4 is the auto-increment flag. Bits [7:5] have no effect.
- R5: With the flag clear, every data byte up to the STOP is written to the selected register, so the last byte wins.
- R6: With the flag set, the first data byte goes to the selected index and each later byte goes to the previous index plus one.
- R7: Data bytes whose index is 8 to 15 are acknowledged but not stored. The 4-bit index wraps from 15 to 0, and bytes after the wrap are stored again.
- R8: A data byte aimed at index 3 is acknowledged and leaves every register unchanged. Byte 3 of `regs_o` is always 0x00.
- R9: A START received in the middle of a byte drops the partial byte and restarts address reception.
- R10: Bytes are shifted in MSB first. `sda_pull_o` rises only while SCL is low after the eighth bit, stays high through the whole ninth clock, and falls after that clock ends.
- R11: The registers hold their values whenever no data byte is accepted, including during traffic for other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| regs_o | output | 64 | Control register bank, byte k at [8k+7:8k] |

## Verification
The bench drives an auto-increment run that starts at index 5. The run crosses the unstored indices 8 to 15 and wraps back to 0. A design with a 3-bit counter would write over registers 0 to 7 too early, and one that stopped at 8 would lose the bytes after the wrap. Writes to index 3 go through both the direct and the incrementing paths, so a design that stored the forbidden slot would show a changed byte 3. Foreign addresses, a set read bit and bytes clocked without a START all check that no acknowledge appears and that no register moves. A START placed after four bits of a byte catches a receiver that keeps a stale bit count, because such a design misreads the following address and stays silent.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned PTR_W    = 4;
  localparam int unsigned AINC_BIT = PTR_W;
  localparam logic [PTR_W-1:0] RSVD_IDX = PTR_W'(3);

  // byte 7 ... byte 0
  localparam logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS =
    {8'hFF, 8'hFF, 8'h0E, 8'h0E, 8'h00, 8'hFF, 8'h0E, 8'h02};

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/tcp_sync.sv
module tcp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '1;
          else        stg[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tcp_rx.sv
module tcp_rx
  import tcp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              sub_wr_o,
  output logic              data_wr_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_o
);
  localparam int unsigned ACK_SLOT = BYTE_W + 1;
  localparam int unsigned CNT_W    = $clog2(ACK_SLOT + 1);

  logic              scl_d, sda_d;
  logic              start_det, stop_det, scl_rise, scl_fall;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_q;

  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ack_q     <= 1'b0;
      sub_wr_o  <= 1'b0;
      data_wr_o <= 1'b0;
    end else begin
      scl_d     <= scl_s;
      sda_d     <= sda_s;
      sub_wr_o  <= 1'b0;
      data_wr_o <= 1'b0;
      if (start_det) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
          bit_cnt <= CNT_W'(ACK_SLOT);
          unique case (phase)
            PH_ADDR: begin
              if (shreg == DEV_ADDR) begin
                ack_q <= 1'b1;
                phase <= PH_SUB;
              end else begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
              end
            end
            PH_SUB: begin
              ack_q    <= 1'b1;
              sub_wr_o <= 1'b1;
              phase    <= PH_DATA;
            end
            PH_DATA: begin
              ack_q     <= 1'b1;
              data_wr_o <= 1'b1;
            end
            default: ;
          endcase
        end else if (scl_fall && bit_cnt == CNT_W'(ACK_SLOT)) begin
          ack_q   <= 1'b0;
          bit_cnt <= '0;
        end
      end
    end
  end

  assign byte_o = shreg;
  assign ack_o  = ack_q;

  // R10
  ack_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !scl_s);
  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && scl_rise) |=> ack_q);
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase == PH_IDLE && !ack_q));
  // R3
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && $past(phase) == PH_ADDR) |-> $past(shreg) == DEV_ADDR);
endmodule

// File: rtl/tcp_bank.sv
module tcp_bank
  import tcp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sub_wr_i,
  input  logic                       data_wr_i,
  input  logic [BYTE_W-1:0]          byte_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [BYTE_W-1:0] bank [NUM_REGS];
  logic [PTR_W-1:0]  ptr;
  logic              ainc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      ainc <= 1'b0;
    end else if (sub_wr_i) begin
      ptr  <= byte_i[PTR_W-1:0];
      ainc <= byte_i[AINC_BIT];
    end else if (data_wr_i && ainc) begin
      ptr  <= ptr + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (PTR_W'(i) == RSVD_IDX) begin : g_rsvd
        assign bank[i] = REG_DEFAULTS[i*BYTE_W +: BYTE_W];
      end else begin : g_live
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            bank[i] <= REG_DEFAULTS[i*BYTE_W +: BYTE_W];
          else if (data_wr_i && ptr == PTR_W'(i))
            bank[i] <= byte_i;
        end
      end
      assign regs_o[i*BYTE_W +: BYTE_W] = bank[i];
    end
  endgenerate

  // R8
  rsvd_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && ptr == RSVD_IDX) |=> $stable(regs_o));
  // R7
  high_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && ptr >= PTR_W'(NUM_REGS)) |=> $stable(regs_o));
  // R6
  ainc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && ainc) |=> ptr == PTR_W'($past(ptr) + 1'b1));
  // R5
  fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && !ainc) |=> $stable(ptr));
  // R5
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && ptr < PTR_W'(NUM_REGS) && ptr != RSVD_IDX)
      |=> regs_o[int'($past(ptr))*BYTE_W +: BYTE_W] == $past(byte_i));
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import tcp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'h88,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [1:0]        bus_s;
  logic              sub_wr, data_wr;
  logic [BYTE_W-1:0] rx_byte;

  tcp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  tcp_rx #(.DEV_ADDR(DEV_ADDR)) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .sub_wr_o  (sub_wr),
    .data_wr_o (data_wr),
    .byte_o    (rx_byte),
    .ack_o     (sda_pull_o)
  );

  tcp_bank i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_wr_i  (sub_wr),
    .data_wr_i (data_wr),
    .byte_i    (rx_byte),
    .regs_o    (regs_o)
  );

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(regs_o));
endmodule

// File: tb/test_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module test_audio_ctl_i2c_slave;
  localparam int Q = 8;
  localparam logic [63:0] DEFS = 64'hFFFF_0E0E_00FF_0E02;
  // {subaddress, data} single-byte writes
  localparam logic [15:0] VEC [8] = '{
    16'h0003, 16'h0105, 16'h022A, 16'h0409,
    16'h0506, 16'h0611, 16'h0722, 16'hE23C
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, sda_bus;
  logic [63:0] regs;
  logic [7:0] mdl [8];
  int checks = 0, fails = 0;

  assign sda_bus = m_sda & ~sda_pull;
  always #2 clk = ~clk;

  audio_ctl_i2c_slave i_audio_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .regs_o(regs)
  );

  function automatic logic [63:0] mvec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic do_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    acked = ~sda_bus;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic wr1(input logic [7:0] sub, input logic [7:0] d, output logic all_ack);
    logic a0, a1, a2;
    do_start();
    send_byte(8'h88, a0); send_byte(sub, a1); send_byte(d, a2);
    do_stop();
    all_ack = a0 & a1 & a2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic ak, ak2;
    logic [7:0] tmp;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(regs === DEFS, "R1 defaults", regs, DEFS);
    chk(sda_pull === 1'b0, "R1 idle pull", {63'b0, sda_pull}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) mdl[i] = DEFS[i*8 +: 8];

    // R4 R5 R10: table of single writes (MSB-first values, upper subaddress bits ignored)
    for (int k = 0; k < 8; k++) begin
      wr1(VEC[k][15:8], VEC[k][7:0], ak);
      mdl[VEC[k][10:8]] = VEC[k][7:0];
      chk(ak === 1'b1, "R4 ack", {63'b0, ak}, 64'h1);
      chk(regs === mvec(), "R10 table write", regs, mvec());
    end

    // R5: fixed index, last byte wins
    do_start(); send_byte(8'h88, ak); send_byte(8'h02, ak);
    send_byte(8'h11, ak); send_byte(8'h12, ak); send_byte(8'h13, ak2); do_stop();
    mdl[2] = 8'h13;
    chk(regs === mvec(), "R5 repeat write", regs, mvec());
    chk(ak2 === 1'b1, "R5 ack", {63'b0, ak2}, 64'h1);

    // R6 R7: auto-increment from 5 through 15, wrap to 0 and 1
    do_start(); send_byte(8'h88, ak); send_byte(8'h15, ak);
    send_byte(8'hA0, ak); send_byte(8'hA1, ak); send_byte(8'hA2, ak);
    ak2 = 1'b1;
    for (int j = 0; j < 8; j++) begin
      send_byte(8'hC0 + 8'(j), ak);
      ak2 &= ak;
    end
    send_byte(8'hB0, ak); send_byte(8'hB1, ak); do_stop();
    mdl[5] = 8'hA0; mdl[6] = 8'hA1; mdl[7] = 8'hA2; mdl[0] = 8'hB0; mdl[1] = 8'hB1;
    chk(regs === mvec(), "R6 increment run", regs, mvec());
    chk(ak2 === 1'b1, "R7 high index ack", {63'b0, ak2}, 64'h1);

    // R8: direct and incrementing writes to index 3
    wr1(8'h03, 8'h55, ak);
    chk(ak === 1'b1, "R8 ack", {63'b0, ak}, 64'h1);
    chk(regs === mvec(), "R8 no change", regs, mvec());
    do_start(); send_byte(8'h88, ak); send_byte(8'h13, ak);
    send_byte(8'h66, ak); send_byte(8'h44, ak); do_stop();
    mdl[4] = 8'h44;
    chk(regs === mvec(), "R8 increment over 3", regs, mvec());

    // R3 R11: foreign address and read bit
    do_start(); send_byte(8'h8A, ak); send_byte(8'h00, ak2); send_byte(8'hAA, tmp[0]); do_stop();
    chk({ak, ak2, tmp[0]} === 3'b000, "R3 foreign nack", {61'b0, ak, ak2, tmp[0]}, 64'h0);
    chk(regs === mvec(), "R11 foreign hold", regs, mvec());
    do_start(); send_byte(8'h89, ak); send_byte(8'h01, ak2); do_stop();
    chk({ak, ak2} === 2'b00, "R3 read bit nack", {62'b0, ak, ak2}, 64'h0);
    chk(regs === mvec(), "R3 read hold", regs, mvec());

    // R2: bytes with no START
    send_byte(8'h88, ak); send_byte(8'h00, ak2); send_byte(8'h77, tmp[0]); do_stop();
    chk({ak, ak2, tmp[0]} === 3'b000, "R2 no start nack", {61'b0, ak, ak2, tmp[0]}, 64'h0);
    chk(regs === mvec(), "R2 no start hold", regs, mvec());

    // R9: START in mid byte
    do_start(); send_byte(8'h88, ak); send_byte(8'h06, ak);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    do_start(); send_byte(8'h88, ak); send_byte(8'h07, ak2); send_byte(8'h5A, tmp[0]); do_stop();
    mdl[7] = 8'h5A;
    chk({ak, ak2, tmp[0]} === 3'b111, "R9 restart ack", {61'b0, ak, ak2, tmp[0]}, 64'h7);
    chk(regs === mvec(), "R9 restart write", regs, mvec());
    chk(sda_pull === 1'b0, "R10 released", {63'b0, sda_pull}, 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule